// File: doc/BRIEF.md
# Serial Flash Write-Protection Controller

This block decides whether a modify operation on a serial flash array may go ahead. It holds a small protection status: a status-lock bit and a four-bit region code. It watches the external write-protect pin, which is active low and is shared with a data line, and from these it works out whether the device is in hardware-locked mode.

A status-register write presents its new value with a one-cycle request. The block answers on the next cycle with a done pulse and a grant flag. A program or erase request presents its target byte address in the same way. Both kinds of array operation are checked identically and are answered one cycle later. Serial command decoding and the array programming itself are done elsewhere.

When the device runs in four-line I/O mode, the pin carries data and the hardware lock is switched off. Only the region code then protects the array.

Top module: `flash_wp_ctrl`

## Requirements
- R1: After reset, `hpm_o`, `status_wd_o`, `status_bp_o`, `sr_wr_done_o`, `sr_wr_ok_o`, `op_done_o` and `op_ok_o` are all 0.
- R2: The pin level passes through a two-flop synchronizer. Hardware-locked mode (`hpm_o`=1) starts on the third clock edge after the pin is sampled low while `status_wd_o`=1 and quad mode is off. This holds whether the lock bit or the low pin came first.
- R3: Once `hpm_o`=1, it stays 1 until the pin has been high for three edges, or until quad mode is asserted. Writing the status bits cannot release it.
- R4: While the pin is held high, `hpm_o` stays 0 whatever the value of the lock bit.
- R5: While `quad_mode_i`=1, `hpm_o` is 0 from the edge after the flag is seen.
- R6: A status write requested while `hpm_o`=1 is answered with `sr_wr_ok_o`=0, and the status bits keep their values.
- R7: A status write requested while `hpm_o`=0 is answered with `sr_wr_ok_o`=1. After that same edge, `status_bp_o` equals `sr_wr_data_i[3:0]` and `status_wd_o` equals `sr_wr_data_i[4]`.
- R8: For region code c from 1 to 6, an array operation is denied exactly when its 24-bit address is at least 2^24 - 2^(17+c). The protected region is the top 2^(17+c) bytes.
- R9: Region code 0 protects nothing. Codes 7 to 15 protect the whole array.
- R10: Each request raises its done output for exactly the one cycle after the request edge, with its grant flag valid in that cycle. Without a request, done and ok are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wp_n_i | input | 1 | Write-protect pin level (low = protect) |
| quad_mode_i | input | 1 | Four-line I/O mode active |
| sr_wr_req_i | input | 1 | Status write request |
| sr_wr_data_i | input | 5 | New status: bit 4 lock bit, bits 3:0 region code |
| op_req_i | input | 1 | Program or erase request |
| op_addr_i | input | 24 | Target byte address |
| hpm_o | output | 1 | Hardware-locked mode active |
| sr_wr_done_o | output | 1 | Status write answered |
| sr_wr_ok_o | output | 1 | Status write granted |
| op_done_o | output | 1 | Array operation answered |
| op_ok_o | output | 1 | Array operation granted |
| status_bp_o | output | 4 | Current region code |
| status_wd_o | output | 1 | Current status-lock bit |

## Verification
A stale or wrong lock state shows up as `hpm_o` out of step with the pin history, three edges after the pin moves. It shows up a cycle later as a status write granted or refused wrongly. A corrupted region code shows up on the next array request as a wrong `op_ok_o` near a region boundary. The bench therefore aims its addresses at those boundaries. It compares every output on every cycle, so a fault is reported within one to three cycles of its cause.

// File: rtl/flash_wp_pkg.sv
package flash_wp_pkg;
  localparam int unsigned BP_W = 4;

  typedef struct packed {
    logic            wd;
    logic [BP_W-1:0] bp;
  } prot_status_t;
endpackage

// File: rtl/flash_wp_sync.sv
module flash_wp_sync #(
  parameter int unsigned STAGES  = 2,
  parameter bit          RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], async_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/flash_wp_hpm.sv
module flash_wp_hpm (
  input  logic clk,
  input  logic rst_n,
  input  logic wp_lvl_i,
  input  logic quad_i,
  input  logic wd_i,
  output logic hpm_o
);
  logic hpm_q, hpm_d;

  always_comb begin
    if (quad_i)     hpm_d = 1'b0;
    else if (hpm_q) hpm_d = !wp_lvl_i;
    else            hpm_d = wd_i && !wp_lvl_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hpm_q <= 1'b0;
    else        hpm_q <= hpm_d;
  end

  assign hpm_o = hpm_q;
endmodule

// File: rtl/flash_wp_region.sv
module flash_wp_region #(
  parameter int unsigned ADDR_W    = 24,
  parameter int unsigned BP_W      = 4,
  parameter int unsigned FULL_CODE = 7
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BP_W-1:0]   code_i,
  output logic              prot_o
);
  localparam int unsigned TOP_BITS = FULL_CODE - 1;

  logic [TOP_BITS-1:0] top_ones;
  int unsigned         need;

  // bit i of top_ones: address bit (ADDR_W-1-i) is set
  for (genvar i = 0; i < TOP_BITS; i++) begin : g_top
    assign top_ones[i] = addr_i[ADDR_W-1-i];
  end

  always_comb begin
    need   = FULL_CODE - int'(code_i);
    prot_o = 1'b0;
    if (int'(code_i) >= FULL_CODE) begin
      prot_o = 1'b1;
    end else if (code_i != '0) begin
      prot_o = 1'b1;
      for (int i = 0; i < TOP_BITS; i++) begin
        if (i < need && !top_ones[i]) prot_o = 1'b0;
      end
    end
  end
endmodule

// File: rtl/flash_wp_ctrl.sv
module flash_wp_ctrl
  import flash_wp_pkg::*;
#(
  parameter int unsigned ADDR_W    = 24,
  parameter int unsigned FULL_CODE = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_n_i,
  input  logic              quad_mode_i,
  input  logic              sr_wr_req_i,
  input  logic [BP_W:0]     sr_wr_data_i,
  input  logic              op_req_i,
  input  logic [ADDR_W-1:0] op_addr_i,
  output logic              hpm_o,
  output logic              sr_wr_done_o,
  output logic              sr_wr_ok_o,
  output logic              op_done_o,
  output logic              op_ok_o,
  output logic [BP_W-1:0]   status_bp_o,
  output logic              status_wd_o
);
  prot_status_t stat_q, stat_d;
  logic         wp_lvl;
  logic         hpm;
  logic         op_prot;
  logic         sr_grant;
  logic         sr_en;
  logic         sr_done_q, sr_ok_q, op_done_q, op_ok_q;
  logic         sr_done_d, sr_ok_d, op_done_d, op_ok_d;

  flash_wp_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (wp_n_i),
    .sync_o  (wp_lvl)
  );

  flash_wp_hpm u_hpm (
    .clk      (clk),
    .rst_n    (rst_n),
    .wp_lvl_i (wp_lvl),
    .quad_i   (quad_mode_i),
    .wd_i     (stat_q.wd),
    .hpm_o    (hpm)
  );

  flash_wp_region #(
    .ADDR_W    (ADDR_W),
    .BP_W      (BP_W),
    .FULL_CODE (FULL_CODE)
  ) u_region (
    .addr_i (op_addr_i),
    .code_i (stat_q.bp),
    .prot_o (op_prot)
  );

  always_comb begin
    sr_grant  = !hpm;
    sr_en     = sr_wr_req_i && sr_grant;
    stat_d    = stat_q;
    if (sr_en) stat_d = prot_status_t'(sr_wr_data_i);
    sr_done_d = sr_wr_req_i;
    sr_ok_d   = sr_en;
    op_done_d = op_req_i;
    op_ok_d   = op_req_i && !op_prot;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
    end else if (sr_en) begin
      stat_q <= stat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_done_q <= 1'b0;
      sr_ok_q   <= 1'b0;
      op_done_q <= 1'b0;
      op_ok_q   <= 1'b0;
    end else begin
      sr_done_q <= sr_done_d;
      sr_ok_q   <= sr_ok_d;
      op_done_q <= op_done_d;
      op_ok_q   <= op_ok_d;
    end
  end

  assign hpm_o        = hpm;
  assign sr_wr_done_o = sr_done_q;
  assign sr_wr_ok_o   = sr_ok_q;
  assign op_done_o    = op_done_q;
  assign op_ok_o      = op_ok_q;
  assign status_bp_o  = stat_q.bp;
  assign status_wd_o  = stat_q.wd;
endmodule

// File: rtl/flash_wp_ctrl_chk.sv
module flash_wp_ctrl_chk #(
  parameter int unsigned FULL_CODE = 7
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wp_n_i,
  input logic       quad_mode_i,
  input logic       sr_wr_req_i,
  input logic       op_req_i,
  input logic       hpm_o,
  input logic       sr_wr_ok_o,
  input logic       op_ok_o,
  input logic [3:0] status_bp_o,
  input logic       status_wd_o
);
  AST_SR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    hpm_o && sr_wr_req_i |=> !sr_wr_ok_o && $stable(status_bp_o) && $stable(status_wd_o)); // R6

  AST_QUAD_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n)
    quad_mode_i |=> !hpm_o); // R5

  AST_HPM_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hpm_o) |-> $past(wp_n_i, 3) || $past(quad_mode_i)); // R3

  AST_FULL_PROT: assert property (@(posedge clk) disable iff (!rst_n)
    op_req_i && (int'(status_bp_o) >= FULL_CODE) |=> !op_ok_o); // R9
endmodule

bind flash_wp_ctrl flash_wp_ctrl_chk #(.FULL_CODE(FULL_CODE)) u_chk (.*);

// File: tb/flash_wp_ctrl_tb.sv
`timescale 1ns/1ps
module flash_wp_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wp_n_i, quad_mode_i, sr_wr_req_i, op_req_i;
  logic [4:0]  sr_wr_data_i;
  logic [23:0] op_addr_i;
  logic        hpm_o, sr_wr_done_o, sr_wr_ok_o, op_done_o, op_ok_o, status_wd_o;
  logic [3:0]  status_bp_o;

  int n_chk = 0;
  int n_bad = 0;

  // bench model state
  logic m_s1, m_s2, m_hpm, m_wd, m_srd, m_srok, m_opd, m_opok;
  logic [3:0] m_bp;

  always #10 clk = ~clk;

  flash_wp_ctrl u_dut (.*);

  function automatic logic exp_prot(input logic [23:0] a, input logic [3:0] c);
    if (c == 0) return 1'b0;
    if (c >= 7) return 1'b1;
    return ({1'b0, a} >= (25'd1 << 24) - (25'd1 << (17 + c)));
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp_all();
    chk(hpm_o == m_hpm, "R2 hpm", hpm_o, m_hpm);
    chk({status_wd_o, status_bp_o} == {m_wd, m_bp}, "R7 status",
        {status_wd_o, status_bp_o}, {m_wd, m_bp});
    chk(sr_wr_ok_o == m_srok, "R6 sr_ok", sr_wr_ok_o, m_srok);
    chk(op_ok_o == m_opok, "R8 op_ok", op_ok_o, m_opok);
    chk({sr_wr_done_o, op_done_o} == {m_srd, m_opd}, "R10 done",
        {sr_wr_done_o, op_done_o}, {m_srd, m_opd});
  endtask

  // one cycle: drive at negedge, model at posedge, compare at next negedge
  task automatic step(input logic pin, input logic quad, input logic srq,
                      input logic [4:0] srdat, input logic opq, input logic [23:0] adr);
    logic nh;
    wp_n_i = pin; quad_mode_i = quad; sr_wr_req_i = srq;
    sr_wr_data_i = srdat; op_req_i = opq; op_addr_i = adr;
    @(posedge clk);
    nh     = quad ? 1'b0 : (m_hpm ? !m_s2 : (m_wd && !m_s2));
    m_srd  = srq;
    m_srok = srq && !m_hpm;
    m_opd  = opq;
    m_opok = opq && !exp_prot(adr, m_bp);
    if (m_srok) begin m_wd = srdat[4]; m_bp = srdat[3:0]; end
    m_hpm = nh;
    m_s2  = m_s1;
    m_s1  = pin;
    @(negedge clk);
    cmp_all();
  endtask

  task automatic idle(input logic pin, input logic quad, input int n);
    for (int i = 0; i < n; i++) step(pin, quad, 1'b0, 5'd0, 1'b0, 24'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0;
    wp_n_i = 1'b1; quad_mode_i = 1'b0; sr_wr_req_i = 1'b0;
    sr_wr_data_i = '0; op_req_i = 1'b0; op_addr_i = '0;
    m_s1 = 1; m_s2 = 1; m_hpm = 0; m_wd = 0; m_bp = 0;
    m_srd = 0; m_srok = 0; m_opd = 0; m_opok = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({hpm_o, status_wd_o, status_bp_o, sr_wr_done_o, sr_wr_ok_o, op_done_o, op_ok_o} == 0,
        "R1 reset", {hpm_o, status_wd_o, status_bp_o}, 0);
    rst_n = 1'b1;
    idle(1, 0, 2);

    // R4: pin high, lock bit set -> never locked
    step(1, 0, 1, 5'b1_0000, 0, 0);
    idle(1, 0, 5);
    chk(hpm_o == 0, "R4 pin high no lock", hpm_o, 0);

    // R2 order A: lock bit first, then pin low
    idle(0, 0, 2);
    chk(hpm_o == 0, "R2 not yet", hpm_o, 0);
    idle(0, 0, 1);
    chk(hpm_o == 1, "R2 lock after pin low", hpm_o, 1);

    // R6: status write blocked
    step(0, 0, 1, 5'b0_0011, 0, 0);
    chk(sr_wr_ok_o == 0 && status_wd_o == 1 && status_bp_o == 0, "R6 blocked write",
        {status_wd_o, status_bp_o}, 5'b1_0000);

    // R3: stays until pin high for three edges
    idle(0, 0, 4);
    chk(hpm_o == 1, "R3 stays locked", hpm_o, 1);
    idle(1, 0, 2);
    chk(hpm_o == 1, "R3 sync delay", hpm_o, 1);
    idle(1, 0, 1);
    chk(hpm_o == 0, "R3 released by pin", hpm_o, 0);

    // R2 order B: pin low first, then lock bit
    step(1, 0, 1, 5'b0_0000, 0, 0);
    idle(0, 0, 4);
    chk(hpm_o == 0, "R2 pin low alone", hpm_o, 0);
    step(0, 0, 1, 5'b1_0010, 0, 0);
    chk(hpm_o == 0 && status_wd_o == 1, "R7 write lands", hpm_o, 0);
    idle(0, 0, 1);
    chk(hpm_o == 1, "R2 lock after bit", hpm_o, 1);

    // R5: quad override, re-lock after quad drops
    idle(0, 1, 1);
    chk(hpm_o == 0, "R5 quad releases", hpm_o, 0);
    step(0, 1, 1, 5'b0_0111, 0, 0);
    chk(sr_wr_ok_o == 1, "R5 write allowed in quad", sr_wr_ok_o, 1);
    idle(0, 1, 3);
    chk(hpm_o == 0, "R5 quad hold", hpm_o, 0);

    // R9: code 7 protects all
    step(0, 0, 0, 0, 1, 24'h000000);
    chk(op_ok_o == 0 && op_done_o == 1, "R9 full protect", op_ok_o, 0);
    step(1, 0, 1, 5'b0_0000, 0, 0);
    idle(1, 0, 3);
    step(1, 0, 0, 0, 1, 24'hFFFFFF);
    chk(op_ok_o == 1, "R9 code0 no protect", op_ok_o, 1);

    // R8 boundaries for each code 1..6
    for (int c = 1; c < 7; c++) begin
      step(1, 0, 1, {1'b0, 4'(c)}, 0, 0);
      step(1, 0, 0, 0, 1, 24'((25'd1 << 24) - (25'd1 << (17 + c))));
      chk(op_ok_o == 0, "R8 first protected", op_ok_o, 0);
      step(1, 0, 0, 0, 1, 24'((25'd1 << 24) - (25'd1 << (17 + c)) - 1));
      chk(op_ok_o == 1, "R8 last open", op_ok_o, 1);
    end

    // random mix
    begin
      logic pin = 1'b1, quad = 1'b0;
      for (int i = 0; i < 4000; i++) begin
        logic [23:0] a;
        if ($urandom_range(0, 15) == 0) pin = ~pin;
        if ($urandom_range(0, 40) == 0) quad = ~quad;
        a = $urandom();
        if ($urandom_range(0, 1) == 1) a[23:18] = 6'h3F;
        step(pin, quad, ($urandom_range(0, 5) == 0), 5'($urandom()),
             ($urandom_range(0, 2) == 0), a);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule